// File: doc/BRIEF.md
# Clocked Serial Shift Channel

The block moves one byte at a time between a parallel register and a serial line. It shifts in step with an external serial clock. The serial clock idles high. On each falling serial-clock edge the block presents its next outgoing bit, most significant bit first. On each rising edge it samples one incoming bit into the least significant position. Each transfer sends and receives a byte at the same time. Software starts a transfer by writing a byte while the channel is enabled. After eight rising edges the block gives a one-cycle completion pulse, and the received byte can be read in parallel.

Two wiring styles are supported. In three-wire mode, data leaves on a dedicated output and enters on a dedicated input. In the two bus modes (plain two-wire and I2C-style), a single open-drain line carries both directions. The block only ever pulls that line low and releases it for a one, so a device that only wants to listen loads all ones. The I2C-style mode adds two controls. Loads need a busy-enable control. A wake-up setting locks out software writes while the block keeps collecting bytes from the line.

The serial clock and the selected data input both pass through two synchronizing flops in the system clock domain. An edge therefore takes effect three system clocks after it arrives.

Top module: `ssc_channel`

## Requirements
- R1: With `en`=1, a write on `wr_en` starts a transfer (`busy`=1). In three-wire mode (`mode`=0), `sdo` presents the written byte most significant bit first, and each new bit appears after a falling `sck_in` edge.
- R2: A write made while `en`=0 is ignored: no transfer starts and `rd_data` keeps its value.
- R3: Incoming data is sampled on rising `sck_in` edges and shifted in at the least significant bit. After eight bits in three-wire mode, `rd_data` equals the byte presented on `sdi`.
- R4: After the eighth rising edge of a transfer, `done` is high for exactly one system clock and `busy` returns to 0.
- R5: In two-wire mode (`mode`=1), the block asserts `sda_oe` (pull low) only while transferring a 0 bit, and it samples `sda_in`. The received byte is therefore the bitwise AND of its own byte and the other driver's byte. A load of 0xFF receives the other side's byte unchanged.
- R6: In I2C-style mode (`mode`=2) without wake-up, a write starts a transfer only when `busy_en`=1. With `busy_en`=0 the write is ignored.
- R7: In I2C-style mode with `wake`=1 and `en`=1, writes are ignored (`rd_data` unchanged, no collision flag) and `sda_oe` stays 0.
- R8: In that wake-up state, every eight rising serial-clock edges capture a byte from `sda_in` into `rd_data` and pulse `done`.
- R9: A write during a transfer is dropped (the transfer's data is unaffected) and sets the sticky flag `wcol`. The next accepted write clears `wcol`.
- R10: In three-wire mode `sda_oe` never asserts. In the bus modes `sdo` is held at 1.
- R11: After reset `busy`, `done`, `wcol` and `sda_oe` are 0 and `sdo` is 1. The value of `rd_data` is not defined until the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable |
| mode | input | 2 | 0 three-wire, 1 two-wire, 2 I2C-style |
| busy_en | input | 1 | Busy enable required for loads in I2C-style mode |
| wake | input | 1 | Wake-up receive setting (I2C-style mode) |
| wr_en | input | 1 | Parallel write strobe |
| wr_data | input | 8 | Parallel write byte |
| rd_data | output | 8 | Parallel read of the shift register |
| sck_in | input | 1 | Serial clock, idle high |
| sdi | input | 1 | Three-wire serial data in |
| sdo | output | 1 | Three-wire serial data out |
| sda_in | input | 1 | Sensed level of the shared bus line |
| sda_oe | output | 1 | Pull the shared line low when 1 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle transfer-complete pulse |
| wcol | output | 1 | Sticky write-collision flag |

## Verification
The assertions assume that each serial-clock level is held for at least two system clocks, so that successive edges never merge after synchronization. They also assume that `mode`, `wake` and `busy_en` change only between transfers. The bench holds every serial-clock half period for four system clocks. It changes the mode controls only while the channel is idle. Data bits are driven at the falling edge, so the line is settled well before the rising-edge sample.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [1:0] {
    SSC_3WIRE = 2'd0,
    SSC_2WIRE = 2'd1,
    SSC_I2C   = 2'd2,
    SSC_RSVD  = 2'd3
  } ssc_mode_e;
endpackage

// File: rtl/ssc_sync2.sv
module ssc_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ssc_edge_detect.sv
module ssc_edge_detect #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic rise,
  output logic fall
);
  logic s_q, s_prev;

  ssc_sync2 #(.RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(sig), .q(s_q)
  );

  always_ff @(posedge clk) begin
    if (rst) s_prev <= IDLE;
    else     s_prev <= s_q;
  end

  assign rise = s_q & ~s_prev;
  assign fall = ~s_q & s_prev;
endmodule

// File: rtl/ssc_bit_counter.sv
module ssc_bit_counter #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic last
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST_V = CW'(N - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (step)    cnt <= (cnt == LAST_V) ? '0 : cnt + 1'b1;
  end

  assign last = (cnt == LAST_V);
endmodule

// File: rtl/ssc_channel.sv
module ssc_channel
  import ssc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic              busy_en,
  input  logic              wake,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sck_in,
  input  logic              sdi,
  output logic              sdo,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic              busy,
  output logic              done,
  output logic              wcol
);
  logic sck_rise, sck_fall;
  logic din_raw, din_s;
  logic is_3w, is_i2c, lock, wr_ok, start, coll, active, shift, last;
  logic out_bit;
  logic [DATA_W-1:0] shreg;

  assign is_3w  = (mode == SSC_3WIRE);
  assign is_i2c = (mode == SSC_I2C);

  ssc_edge_detect #(.IDLE(1'b1)) u_sck (
    .clk(clk), .rst(rst), .sig(sck_in), .rise(sck_rise), .fall(sck_fall)
  );

  assign din_raw = is_3w ? sdi : sda_in;

  ssc_sync2 #(.RST_VAL(1'b1)) u_din (
    .clk(clk), .rst(rst), .d(din_raw), .q(din_s)
  );

  // wake-up lockout: reception only, software loads refused
  assign lock   = en && is_i2c && wake;
  assign wr_ok  = wr_en && en && !lock && (!is_i2c || busy_en);
  assign start  = wr_ok && !busy;
  assign coll   = wr_ok && busy;
  assign active = busy || lock;
  assign shift  = active && sck_rise;

  ssc_bit_counter #(.N(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(!active), .step(shift), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      wcol    <= 1'b0;
      out_bit <= 1'b1;
      shreg   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        shreg   <= wr_data;
        busy    <= 1'b1;
        out_bit <= 1'b1;
        wcol    <= 1'b0;
      end else begin
        if (coll) wcol <= 1'b1;
        if (shift) begin
          shreg <= {shreg[DATA_W-2:0], din_s};
          if (last) begin
            done <= 1'b1;
            busy <= 1'b0;
          end
        end
        if (active && sck_fall) out_bit <= shreg[DATA_W-1];
      end
    end
  end

  assign rd_data = shreg;
  assign sdo     = is_3w ? out_bit : 1'b1;
  assign sda_oe  = busy && !is_3w && !lock && !out_bit;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4
  AST_DONE_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(sck_rise)); // R4
  AST_OFF_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !en && !busy) |=> !busy); // R2
  AST_WAKE_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && lock && !sck_rise) |=> (rd_data == $past(rd_data))); // R7
  AST_WCOL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wcol && !(wr_en && en && !busy)) |=> wcol); // R9
endmodule

// File: tb/ssc_channel_tb.sv
module ssc_channel_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, busy_en = 1'b0, wake = 1'b0, wr_en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic sck_in = 1'b1, sdi = 1'b1, ext_drv = 1'b1;
  logic sdo, sda_oe, sda_in, busy, done, wcol;

  int checks = 0, fails = 0, done_cnt = 0, oe3w_cnt = 0, sdo_bus_low = 0;

  always #2 clk = ~clk;

  assign sda_in = ext_drv & ~sda_oe;

  ssc_channel u_dut (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .busy_en(busy_en), .wake(wake),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .sck_in(sck_in),
    .sdi(sdi), .sdo(sdo), .sda_in(sda_in), .sda_oe(sda_oe), .busy(busy),
    .done(done), .wcol(wcol)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (done) done_cnt++;
      if (sda_oe && mode == 2'd0) oe3w_cnt++;
      if (!sdo && mode != 2'd0) sdo_bus_low++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_byte(input logic [7:0] d);
    tick(1);
    wr_en = 1'b1; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  // eight serial bits; optional colliding write before bit index coll_at
  task automatic run_bits(input logic [7:0] sdi_b, input logic [7:0] ext_b,
                          input int coll_at, input logic [7:0] coll_d,
                          output logic [7:0] seen);
    for (int i = 7; i >= 0; i--) begin
      if (i == coll_at) write_byte(coll_d);
      sck_in = 1'b0; sdi = sdi_b[i]; ext_drv = ext_b[i];
      tick(4);
      seen[i] = sdo;
      sck_in = 1'b1;
      tick(4);
    end
    ext_drv = 1'b1;
    tick(2);
  endtask

  task automatic xfer(input logic [1:0] m, input logic [7:0] w,
                      input logic [7:0] sdi_b, input logic [7:0] ext_b);
    logic [7:0] seen;
    int d0;
    mode = m;
    d0 = done_cnt;
    write_byte(w);
    chk("R1 busy after write", busy, 1);
    run_bits(sdi_b, ext_b, -1, 8'h00, seen);
    if (m == 2'd0) begin
      chk("R1 sdo stream", seen, w);
      chk("R3 received byte", rd_data, sdi_b);
    end else begin
      chk("R5 wired-AND byte", rd_data, w & ext_b);
    end
    chk("R4 one done pulse", done_cnt - d0, 1);
    chk("R4 busy cleared", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] seen, prev;
    int d0;
    void'($urandom(32'd4242));
    tick(3);
    rst = 1'b0;
    tick(1);
    // R11 reset state
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 wcol", wcol, 0);
    chk("R11 sda_oe", sda_oe, 0);
    chk("R11 sdo", sdo, 1);

    // R2 write while disabled
    en = 1'b0;
    write_byte(8'h5A);
    en = 1'b1;
    write_byte(8'hC3);
    run_bits(8'h00, 8'hFF, -1, 8'h00, seen);
    prev = rd_data;
    en = 1'b0;
    d0 = done_cnt;
    write_byte(8'h11);
    chk("R2 no busy", busy, 0);
    run_bits(8'hFF, 8'hFF, -1, 8'h00, seen);
    chk("R2 rd unchanged", rd_data, prev);
    chk("R2 no done", done_cnt - d0, 0);
    en = 1'b1;

    // directed corner bytes
    xfer(2'd0, 8'h80, 8'h01, 8'hFF);
    xfer(2'd0, 8'h01, 8'h80, 8'hFF);
    xfer(2'd1, 8'hFF, 8'hFF, 8'h6C);
    xfer(2'd1, 8'h0F, 8'hFF, 8'hF0);

    // random mix
    for (int k = 0; k < 16; k++) begin
      logic [1:0] m;
      m = ($urandom % 2 == 0) ? 2'd0 : 2'd1;
      xfer(m, 8'($urandom), 8'($urandom), 8'($urandom));
    end

    // R9 collision
    mode = 2'd0;
    write_byte(8'hA5);
    run_bits(8'h3C, 8'hFF, 4, 8'h00, seen);
    chk("R9 sdo unaffected", seen, 8'hA5);
    chk("R9 rd unaffected", rd_data, 8'h3C);
    chk("R9 wcol set", wcol, 1);
    write_byte(8'h12);
    chk("R9 wcol cleared", wcol, 0);
    run_bits(8'h00, 8'hFF, -1, 8'h00, seen);

    // R6 busy enable in I2C-style mode
    mode = 2'd2; busy_en = 1'b0;
    prev = rd_data;
    write_byte(8'hFF);
    chk("R6 refused without busy_en", busy, 0);
    chk("R6 rd unchanged", rd_data, prev);
    busy_en = 1'b1;
    xfer(2'd2, 8'hFF, 8'h00, 8'h3A);
    chk("R6 receive with busy_en", rd_data, 8'h3A);

    // R7 and R8 wake-up
    wake = 1'b1;
    prev = rd_data;
    write_byte(8'h00);
    chk("R7 write ignored busy", busy, 0);
    chk("R7 rd unchanged", rd_data, prev);
    chk("R7 no wcol", wcol, 0);
    chk("R7 line released", sda_oe, 0);
    d0 = done_cnt;
    run_bits(8'h00, 8'h96, -1, 8'h00, seen);
    chk("R8 wake byte", rd_data, 8'h96);
    chk("R8 wake done", done_cnt - d0, 1);
    run_bits(8'h00, 8'h4B, 3, 8'h00, seen);
    chk("R8 second wake byte", rd_data, 8'h4B);
    chk("R7 no wcol after write", wcol, 0);
    wake = 1'b0; busy_en = 1'b0;

    chk("R10 sda_oe in three-wire", oe3w_cnt, 0);
    chk("R10 sdo held in bus modes", sdo_bus_low, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule